// File: doc/BRIEF.md
# Scalar Two-Source ALU with Condition Flag

This block executes one scalar two-operand instruction per accepted cycle. It takes a 32-bit instruction word and extracts the opcode and the encoding-type field from it. It then applies the selected operation to two 64-bit operand values that the surrounding pipeline has already fetched. Operations with a 32-bit form use only the low half of each operand. The block also has a single-bit condition flag as input, and it produces a new value for that flag.

Each opcode group has its own rule for the flag:
- carry or borrow for the unsigned arithmetic,
- signed overflow for the signed arithmetic,
- which operand won, for min and max,
- a non-zero test on the result, for the logic, shift and absolute-difference operations,
- no write at all, for select and multiply.

All outputs are registered, so a result appears one clock after its input. An instruction word with the wrong encoding type, or with an opcode that has no operation here, is flagged as illegal.

Top module: `salu2`

## Requirements
- R1: Bits 31:30 of the instruction word hold the encoding type and bits 29:23 hold the opcode. When the encoding type is not binary 10, the result is illegal: `illegal`=1, `result`=0, `cond_we`=0.
- R2: `res_valid` rises exactly one clock after an accepted input (`in_valid`=1) and is 0 after a cycle with no input. All outputs are 0 after reset.
- R3: Opcode 0 (unsigned add) writes the carry out of bit 31 to the flag. Opcode 4 also adds the incoming flag into the sum.
- R4: Opcodes 2 (signed add) and 3 (signed subtract) give the 32-bit wrapped result. They set the flag when the exact signed result lies outside -2^31..2^31-1.
- R5: Opcode 1 (unsigned subtract) sets the flag on borrow. Opcode 5 also subtracts the incoming flag, and it reports its borrow the same way.
- R6: Opcodes 6, 7, 8 and 9 are signed min, unsigned min, signed max and unsigned max. The flag is 1 only when operand A won the strict comparison.
- R7: Opcode 10 (32-bit) and opcode 11 (64-bit) output A when the incoming flag is 1 and B when it is 0. They do not write the flag.
- R8: Opcodes 12 to 27 are the logic operations, each in pairs with the 32-bit form on the even opcode and the 64-bit form on the odd opcode. In order the pairs are AND, OR, XOR, A AND NOT B, A OR NOT B, NAND, NOR and XNOR. The flag is set to result != 0.
- R9: Opcodes 28 to 33 are the shifts, in pairs with the 32-bit form even and the 64-bit form odd. In order they are logical left, logical right and arithmetic right. The shift count is B masked to 5 bits (32-bit form) or 6 bits (64-bit form). The flag is set to result != 0.
- R10: Opcode 36 outputs the low 32 bits of A*B and does not write the flag.
- R11: Opcode 42 outputs |A-B| with A and B taken as signed 32-bit values. The flag is set to result != 0.
- R12: Any other opcode is illegal: `illegal`=1, `result`=0, `cond_we`=0.
- R13: Every 32-bit form clears `result[63:32]`. Whenever a valid result has `cond_we`=0, `cond_out` repeats the incoming flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| cond_in | input | 1 | Current condition flag |
| result | output | 64 | Registered result |
| res_valid | output | 1 | Result valid strobe |
| cond_out | output | 1 | New condition flag |
| cond_we | output | 1 | Condition flag write enable |
| illegal | output | 1 | Encoding or opcode not supported |

## Verification
The assertions assume that `in_valid` is low throughout reset. They also assume that the inputs sampled with `in_valid` high are the ones that define the next cycle's outputs. No back-to-back dependency between instructions is assumed. The bench drives every input at the falling edge and holds it for one full cycle, and it returns `in_valid` to 0 between instructions. The flag therefore always comes from the bench and never from the block's own output. Stimulus covers legal and illegal encodings, so the illegal-path assertions are exercised as well as the normal ones.

// File: rtl/salu2.sv
module salu2 #(
  parameter int XLEN = 64,
  parameter int HLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            cond_in,
  output logic [XLEN-1:0] result,
  output logic            res_valid,
  output logic            cond_out,
  output logic            cond_we,
  output logic            illegal
);
  localparam int SH32 = $clog2(HLEN);
  localparam int SH64 = $clog2(XLEN);

  logic [6:0]      op;
  logic            enc_ok;
  logic [HLEN-1:0] a, b;
  logic [HLEN:0]   add_u, sub_u, add_s, sub_s;
  logic [HLEN-1:0] absd, mulv;
  logic [XLEN-1:0] lg, sh;
  logic [XLEN-1:0] n_res;
  logic            n_cond, n_we, n_ill, wide;

  assign op     = instr[29:23];
  assign enc_ok = instr[31:30] == 2'b10;
  assign a      = opa[HLEN-1:0];
  assign b      = opb[HLEN-1:0];
  assign wide   = op[0];

  assign add_u = {1'b0, a} + {1'b0, b} + {{HLEN{1'b0}}, cond_in & (op == 7'd4)};
  assign sub_u = {1'b0, a} - {1'b0, b} - {{HLEN{1'b0}}, cond_in & (op == 7'd5)};
  assign add_s = {a[HLEN-1], a} + {b[HLEN-1], b};
  assign sub_s = {a[HLEN-1], a} - {b[HLEN-1], b};
  assign absd  = sub_s[HLEN] ? (~sub_s[HLEN-1:0] + 1'b1) : sub_s[HLEN-1:0];
  assign mulv  = a * b;

  always_comb begin
    unique case (op[3:1])
      3'd6:    lg = opa & opb;
      3'd7:    lg = opa | opb;
      3'd0:    lg = opa ^ opb;
      3'd1:    lg = opa & ~opb;
      3'd2:    lg = opa | ~opb;
      3'd3:    lg = ~(opa & opb);
      3'd4:    lg = ~(opa | opb);
      default: lg = ~(opa ^ opb);
    endcase
    if (!wide) lg[XLEN-1:HLEN] = '0;
  end

  always_comb begin
    sh = '0;
    case (op)
      7'd28: sh[HLEN-1:0] = a << b[SH32-1:0];
      7'd29: sh = opa << opb[SH64-1:0];
      7'd30: sh[HLEN-1:0] = a >> b[SH32-1:0];
      7'd31: sh = opa >> opb[SH64-1:0];
      7'd32: sh[HLEN-1:0] = $unsigned($signed(a) >>> b[SH32-1:0]);
      7'd33: sh = $unsigned($signed(opa) >>> opb[SH64-1:0]);
      default: sh = '0;
    endcase
  end

  always_comb begin
    n_res  = '0;
    n_cond = cond_in;
    n_we   = 1'b1;
    n_ill  = 1'b0;
    case (op)
      7'd0, 7'd4: begin n_res[HLEN-1:0] = add_u[HLEN-1:0]; n_cond = add_u[HLEN]; end
      7'd1, 7'd5: begin n_res[HLEN-1:0] = sub_u[HLEN-1:0]; n_cond = sub_u[HLEN]; end
      7'd2: begin n_res[HLEN-1:0] = add_s[HLEN-1:0]; n_cond = add_s[HLEN] ^ add_s[HLEN-1]; end
      7'd3: begin n_res[HLEN-1:0] = sub_s[HLEN-1:0]; n_cond = sub_s[HLEN] ^ sub_s[HLEN-1]; end
      7'd6: begin n_cond = $signed(a) < $signed(b); n_res[HLEN-1:0] = n_cond ? a : b; end
      7'd7: begin n_cond = a < b; n_res[HLEN-1:0] = n_cond ? a : b; end
      7'd8: begin n_cond = $signed(a) > $signed(b); n_res[HLEN-1:0] = n_cond ? a : b; end
      7'd9: begin n_cond = a > b; n_res[HLEN-1:0] = n_cond ? a : b; end
      7'd10: begin n_res[HLEN-1:0] = cond_in ? a : b; n_we = 1'b0; end
      7'd11: begin n_res = cond_in ? opa : opb; n_we = 1'b0; end
      7'd36: begin n_res[HLEN-1:0] = mulv; n_we = 1'b0; end
      7'd42: begin n_res[HLEN-1:0] = absd; n_cond = |absd; end
      default: begin
        if (op >= 7'd12 && op <= 7'd27) begin
          n_res = lg; n_cond = |lg;
        end else if (op >= 7'd28 && op <= 7'd33) begin
          n_res = sh; n_cond = |sh;
        end else begin
          n_ill = 1'b1; n_we = 1'b0;
        end
      end
    endcase
    if (!enc_ok) begin
      n_res = '0; n_cond = cond_in; n_we = 1'b0; n_ill = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      result    <= '0;
      res_valid <= 1'b0;
      cond_out  <= 1'b0;
      cond_we   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      result    <= n_res;
      res_valid <= 1'b1;
      cond_out  <= n_cond;
      cond_we   <= n_we;
      illegal   <= n_ill;
    end
  end
endmodule

// File: rtl/salu2_chk.sv
module salu2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        cond_in,
  input logic [63:0] result,
  input logic        res_valid,
  input logic        cond_out,
  input logic        cond_we,
  input logic        illegal
);
  logic good;
  assign good = in_valid && instr[31:30] == 2'b10;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  p_bad_encoding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:30] != 2'b10) |=> (illegal && !cond_we && result == 64'd0));
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == 64'd0 && !cond_we));
  p_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (good && instr[29:23] == 7'd11) |=>
      (!cond_we && result == ($past(cond_in) ? $past(opa) : $past(opb))));
  p_mul_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (good && instr[29:23] == 7'd36) |=> (!cond_we && result[63:32] == 32'd0));
  p_hold_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cond_we) |-> cond_out == $past(cond_in));
endmodule

bind salu2 salu2_chk u_chk (.*);

// File: tb/salu2_tb.sv
module salu2_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        cond_in = 1'b0;
  logic [63:0] result;
  logic        res_valid, cond_out, cond_we, illegal;
  int errors = 0, checks = 0;

  salu2 u_dut (.*);

  always #2 clk = ~clk;

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] er, input logic ec,
                     input logic ew, input logic ei);
    checks++;
    if (!res_valid || result !== er || cond_out !== ec || cond_we !== ew || illegal !== ei) begin
      errors++;
      $display("FAIL %s: got v=%b r=%h c=%b w=%b i=%b exp v=1 r=%h c=%b w=%b i=%b",
               tag, res_valid, result, cond_out, cond_we, illegal, er, ec, ew, ei);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] enc, input logic [6:0] op,
                     input logic [63:0] a, input logic [63:0] b, input logic ci,
                     input logic [63:0] er, input logic ec, input logic ew, input logic ei);
    @(negedge clk);
    in_valid = 1'b1; instr = {enc, op, 7'd3, 8'd2, 8'd1}; opa = a; opb = b; cond_in = ci;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, er, ec, ew, ei);
  endtask

  task automatic t_reset;
    checks++;
    if (result !== 0 || res_valid || cond_out || cond_we || illegal) begin
      errors++; $display("FAIL R2 reset: r=%h v=%b exp all zero", result, res_valid);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R2 idle: v=%b exp 0", res_valid);
    end
  endtask

  task automatic t_arith;
    run("R3 add carry", 2'b10, 7'd0, 64'hffffffff, 64'd1, 0, 64'd0, 1, 1, 0);
    run("R3 addc", 2'b10, 7'd4, 64'd5, 64'd6, 1, 64'd12, 0, 1, 0);
    run("R4 add ovf", 2'b10, 7'd2, 64'h7fffffff, 64'd1, 0, 64'h80000000, 1, 1, 0);
    run("R4 add no ovf", 2'b10, 7'd2, 64'hffffffff, 64'd1, 1, 64'd0, 0, 1, 0);
    run("R4 sub ovf", 2'b10, 7'd3, 64'h80000000, 64'd1, 0, 64'h7fffffff, 1, 1, 0);
    run("R5 sub borrow", 2'b10, 7'd1, 64'd3, 64'd5, 0, 64'hfffffffe, 1, 1, 0);
    run("R5 sub none", 2'b10, 7'd1, 64'd5, 64'd3, 1, 64'd2, 0, 1, 0);
    run("R5 subb", 2'b10, 7'd5, 64'd5, 64'd5, 1, 64'hffffffff, 1, 1, 0);
    run("R13 upper cleared", 2'b10, 7'd0, 64'hdeadbeef_00000001, 64'h1_00000001, 0, 64'd2, 0, 1, 0);
  endtask

  task automatic t_minmax;
    run("R6 min_i", 2'b10, 7'd6, 64'hffffffff, 64'd1, 0, 64'hffffffff, 1, 1, 0);
    run("R6 min_u", 2'b10, 7'd7, 64'hffffffff, 64'd1, 1, 64'd1, 0, 1, 0);
    run("R6 max_i tie", 2'b10, 7'd8, 64'd5, 64'd5, 1, 64'd5, 0, 1, 0);
    run("R6 max_u", 2'b10, 7'd9, 64'hffffffff, 64'd1, 0, 64'hffffffff, 1, 1, 0);
  endtask

  task automatic t_select;
    run("R7 sel32 a", 2'b10, 7'd10, 64'h1234_aaaa5555, 64'h77, 1, 64'haaaa5555, 1, 0, 0);
    run("R7 sel64 b", 2'b10, 7'd11, 64'h11, 64'hcafe0000_beef0000, 0, 64'hcafe0000_beef0000, 0, 0, 0);
  endtask

  task automatic t_logic;
    run("R8 and64", 2'b10, 7'd13, 64'hf0f0f0f0_f0f0f0f0, 64'h0f0f0f0f_0f0f0f0f, 1, 64'd0, 0, 1, 0);
    run("R8 or32", 2'b10, 7'd14, 64'hff00_00000f00, 64'h000000f0, 0, 64'h00000ff0, 1, 1, 0);
    run("R8 andn2_32", 2'b10, 7'd18, 64'hff, 64'h0f, 0, 64'hf0, 1, 1, 0);
    run("R8 orn2_64", 2'b10, 7'd21, 64'd0, 64'hffffffff_ffffffff, 1, 64'd0, 0, 1, 0);
    run("R8 nand32", 2'b10, 7'd22, 64'hffffffff, 64'h0000ffff, 0, 64'hffff0000, 1, 1, 0);
    run("R8 xnor32", 2'b10, 7'd26, 64'd0, 64'd0, 0, 64'hffffffff, 1, 1, 0);
  endtask

  task automatic t_shift;
    run("R9 lshl32 mask", 2'b10, 7'd28, 64'd1, 64'h23, 0, 64'd8, 1, 1, 0);
    run("R9 lshl64 mask", 2'b10, 7'd29, 64'd1, 64'd64, 0, 64'd1, 1, 1, 0);
    run("R9 lshr64", 2'b10, 7'd31, 64'h80000000_00000000, 64'h7f, 0, 64'd1, 1, 1, 0);
    run("R9 ashr32", 2'b10, 7'd32, 64'h80000000, 64'd31, 0, 64'hffffffff, 1, 1, 0);
    run("R9 ashr64", 2'b10, 7'd33, 64'h80000000_00000000, 64'd4, 0, 64'hf8000000_00000000, 1, 1, 0);
    run("R9 lshr32 zero", 2'b10, 7'd30, 64'h1, 64'd1, 1, 64'd0, 0, 1, 0);
  endtask

  task automatic t_misc;
    run("R10 mul", 2'b10, 7'd36, 64'h10000, 64'h10001, 1, 64'h00010000, 1, 0, 0);
    run("R11 absdiff", 2'b10, 7'd42, 64'd3, 64'd10, 0, 64'd7, 1, 1, 0);
    run("R11 absdiff zero", 2'b10, 7'd42, 64'd5, 64'd5, 1, 64'd0, 0, 1, 0);
    run("R11 absdiff signed", 2'b10, 7'd42, 64'h80000000, 64'd1, 0, 64'h80000001, 1, 1, 0);
  endtask

  task automatic t_illegal;
    run("R12 op34", 2'b10, 7'd34, 64'd1, 64'd1, 1, 64'd0, 1, 0, 1);
    run("R12 op100", 2'b10, 7'd100, 64'd1, 64'd1, 0, 64'd0, 0, 0, 1);
    run("R1 enc01", 2'b01, 7'd0, 64'd1, 64'd1, 0, 64'd0, 0, 0, 1);
    run("R1 enc11", 2'b11, 7'd14, 64'd1, 64'd1, 1, 64'd0, 1, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_idle;
    t_arith;
    t_minmax;
    t_select;
    t_logic;
    t_shift;
    t_misc;
    t_illegal;
    t_idle;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule